// File: doc/BRIEF.md
# Flash bus interface front end

This block is the device-side bus interface of a parallel NOR-style flash memory. It sits between the external pins and the internal array, identifier, query and status sources. It also sits between the pins and the write state machine. From three chip enables and an output enable it works out whether the device is selected and reading. A width-select input chooses 16-bit or 8-bit operation.

In 8-bit operation the lowest address bit picks one byte of the addressed word, and the upper data lane stays off the bus. The block produces per-bit tri-state enables for both data lanes. It narrows those enables for status reads, and narrows them further while the write state machine is busy. Writes are captured on the rising edge of the write strobe and handed inward as a one-cycle event.

A two-bit read-mode register chooses the read source. A stubbed command decoder sets it. An open-drain status pin is modelled as a pull-low enable. It follows the busy flag in level mode, or gives a fixed-length pulse on each completion event in pulse mode.

Top module: `flash_bus_front`

## Requirements
- R1: Both data lanes have all enables at 0 unless ce0_n=0, ce1_n=0, ce2=1, oe_n=0 and pd_n=1 all hold at once. Clearing any one of these terms removes the drive.
- R2: With wide_mode=1 (16-bit) and a non-status read mode, all 16 enables are 1 and dq_out equals the selected 16-bit source word. addr[0] has no effect on dq_out.
- R3: With wide_mode=0 (8-bit), enables 15..8 are 0. The low lane carries source bits 15..8 when addr[0]=1 and source bits 7..0 when addr[0]=0.
- R4: word_addr always equals addr[ADDR_W-1:1], in both widths.
- R5: The read-mode encoding is 0 array, 1 identifier, 2 query, 3 status. A pulse on mode_set_valid loads mode_set_val, and the new source appears on the bus from the next clock edge.
- R6: In status mode (3) only enables 7..0 are 1, and dq_out[7:0] equals status_in. This holds in both widths and for either value of addr[0].
- R7: While wsm_busy=1 during a read, only enable bit 7 is 1 and dq_out[7]=0, which reports busy.
- R8: The rising edge of we_n while selected and out of reset gives wr_valid=1 for exactly one cycle. It is visible after the first clock edge at which we_n is seen high after being seen low. It carries wr_word_addr=addr[ADDR_W-1:1], wr_byte_hi=addr[0] in 8-bit mode and 0 in 16-bit mode, wr_wide=wide_mode and wr_data=dq_in, all as sampled at that edge.
- R9: A write-strobe rising edge while not selected (any chip-enable term false) gives no wr_valid.
- R10: pd_n=0 clears the read mode to array and blocks writes. After pd_n returns to 1, reads come from the array source.
- R11: With sts_pulse_mode=0, sts_pull_low equals wsm_busy.
- R12: With sts_pulse_mode=1, a cycle with done_evt=1 makes sts_pull_low 1 for exactly PULSE_LEN cycles, starting after that clock edge. A new event restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; bus inputs are sampled on it |
| pd_n | input | 1 | Reset/power-down, active low |
| ce0_n | input | 1 | Chip enable term, active low |
| ce1_n | input | 1 | Chip enable term, active low |
| ce2 | input | 1 | Chip enable term, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; capture on rising edge |
| wide_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| addr | input | ADDR_W | External address; bit 0 is the byte select in 8-bit mode |
| dq_in | input | 2*LANE_W | Data bus input side |
| dq_out | output | 2*LANE_W | Data bus output values |
| dq_oe | output | 2*LANE_W | Per-bit output enables |
| word_addr | output | ADDR_W-1 | Internal word address for reads |
| array_rdata | input | 2*LANE_W | Array read word |
| ident_rdata | input | 2*LANE_W | Identifier read word |
| query_rdata | input | 2*LANE_W | Query read word |
| status_in | input | LANE_W | Status register byte |
| mode_set_valid | input | 1 | Load strobe for the read-mode register |
| mode_set_val | input | 2 | New read mode |
| wsm_busy | input | 1 | Write state machine busy |
| done_evt | input | 1 | Program/erase completion event |
| sts_pulse_mode | input | 1 | 0 = level status pin, 1 = pulse on completion |
| sts_pull_low | output | 1 | Pull-low enable of the open-drain status pin |
| wr_valid | output | 1 | One-cycle captured write |
| wr_word_addr | output | ADDR_W-1 | Captured word address |
| wr_byte_hi | output | 1 | Captured byte select (0 in 16-bit mode) |
| wr_wide | output | 1 | Captured width mode |
| wr_data | output | 2*LANE_W | Captured data bus |

## Verification
The bench builds the block with ADDR_W=6, LANE_W=8 and PULSE_LEN=4. With a 6-bit address, the top word-address bit and both values of the byte select are easy to reach in directed patterns. The array stub returns a word derived from word_addr, so an address error shows up on the data lanes. PULSE_LEN=4 keeps each status pulse short enough that the bench can check the last asserted cycle and the first released cycle. It can also retrigger the pulse in the middle of a count.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
   typedef enum logic [1:0] {
      RD_ARRAY  = 2'd0,
      RD_IDENT  = 2'd1,
      RD_QUERY  = 2'd2,
      RD_STATUS = 2'd3
   } rd_mode_e;

   localparam int unsigned BUSY_BIT = 7;
endpackage

// File: rtl/fbf_select.sv
module fbf_select (
   input  logic ce0_n,
   input  logic ce1_n,
   input  logic ce2,
   input  logic oe_n,
   input  logic pd_n,
   output logic sel,
   output logic rd_en
);
   // Selected only while all three enable terms agree; first term to drop deselects.
   assign sel   = ~ce0_n & ~ce1_n & ce2 & pd_n;
   assign rd_en = sel & ~oe_n;
endmodule

// File: rtl/fbf_write_latch.sv
module fbf_write_latch #(
   parameter int unsigned ADDR_W = 23,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              pd_n,
   input  logic              sel,
   input  logic              we_n,
   input  logic              wide_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic              wr_valid,
   output logic [ADDR_W-2:0] wr_word_addr,
   output logic              wr_byte_hi,
   output logic              wr_wide,
   output logic [DATA_W-1:0] wr_data
);
   logic we_q;
   logic we_rise;

   assign we_rise = ~we_q & we_n & sel;

   always_ff @(posedge clk or negedge pd_n) begin
      if (!pd_n) begin
         we_q         <= 1'b1;
         wr_valid     <= 1'b0;
         wr_word_addr <= '0;
         wr_byte_hi   <= 1'b0;
         wr_wide      <= 1'b0;
         wr_data      <= '0;
      end else begin
         we_q     <= we_n;
         wr_valid <= we_rise;
         if (we_rise) begin
            wr_word_addr <= addr[ADDR_W-1:1];
            wr_byte_hi   <= ~wide_mode & addr[0];
            wr_wide      <= wide_mode;
            wr_data      <= dq_in;
         end
      end
   end

   AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!pd_n)
      wr_valid |=> !wr_valid); // R8
   AST_WR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!pd_n)
      wr_valid |-> $past(sel)); // R9
endmodule

// File: rtl/fbf_read_path.sv
module fbf_read_path
   import fbf_pkg::*;
#(
   parameter int unsigned LANE_W = 8
) (
   input  logic                clk,
   input  logic                pd_n,
   input  logic                rd_en,
   input  logic                wide_mode,
   input  logic                byte_hi,
   input  logic                busy,
   input  logic                mode_set_valid,
   input  logic [1:0]          mode_set_val,
   input  logic [2*LANE_W-1:0] array_rdata,
   input  logic [2*LANE_W-1:0] ident_rdata,
   input  logic [2*LANE_W-1:0] query_rdata,
   input  logic [LANE_W-1:0]   status_in,
   output logic [2*LANE_W-1:0] dq_out,
   output logic [2*LANE_W-1:0] dq_oe
);
   localparam int unsigned DATA_W = 2 * LANE_W;

   rd_mode_e          mode;
   logic [DATA_W-1:0] src_word;
   logic              is_status;

   always_ff @(posedge clk or negedge pd_n) begin
      if (!pd_n)               mode <= RD_ARRAY;
      else if (mode_set_valid) mode <= rd_mode_e'(mode_set_val);
   end

   always_comb begin
      unique case (mode)
         RD_IDENT: src_word = ident_rdata;
         RD_QUERY: src_word = query_rdata;
         default:  src_word = array_rdata;
      endcase
   end

   assign is_status = (mode == RD_STATUS);

   for (genvar ln = 0; ln < 2; ln++) begin : g_lane
      logic [LANE_W-1:0] val;
      logic [LANE_W-1:0] en;
      if (ln == 0) begin : g_low
         always_comb begin
            if (is_status)      val = status_in;
            else if (byte_hi)   val = src_word[DATA_W-1:LANE_W];
            else                val = src_word[LANE_W-1:0];
            en = {LANE_W{rd_en}};
            if (busy) begin
               en  = '0;
               en[BUSY_BIT] = rd_en;
               val[BUSY_BIT] = 1'b0;
            end
         end
      end else begin : g_high
         always_comb begin
            val = src_word[DATA_W-1:LANE_W];
            en  = {LANE_W{rd_en & wide_mode & ~is_status & ~busy}};
         end
      end
      assign dq_out[ln*LANE_W +: LANE_W] = val;
      assign dq_oe[ln*LANE_W +: LANE_W]  = en;
   end

   AST_DESEL_FLOAT: assert property (@(posedge clk) disable iff (!pd_n)
      !rd_en |-> dq_oe == '0); // R1
   AST_BYTE_HI_FLOAT: assert property (@(posedge clk) disable iff (!pd_n)
      !wide_mode |-> dq_oe[DATA_W-1:LANE_W] == '0); // R3
   AST_STATUS_LOW_LANE: assert property (@(posedge clk) disable iff (!pd_n)
      is_status |-> dq_oe[DATA_W-1:LANE_W] == '0); // R6
   AST_BUSY_B7_ONLY: assert property (@(posedge clk) disable iff (!pd_n)
      busy |-> (dq_oe & ~(DATA_W'(1) << BUSY_BIT)) == '0); // R7
   AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!pd_n)
      mode_set_valid |=> mode == rd_mode_e'($past(mode_set_val))); // R5
endmodule

// File: rtl/fbf_sts_drive.sv
module fbf_sts_drive #(
   parameter int unsigned PULSE_LEN = 4
) (
   input  logic clk,
   input  logic pd_n,
   input  logic pulse_mode,
   input  logic busy,
   input  logic done_evt,
   output logic pull_low
);
   localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge pd_n) begin
      if (!pd_n)              cnt <= '0;
      else if (done_evt)      cnt <= CNT_W'(PULSE_LEN);
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign pull_low = pulse_mode ? (cnt != '0) : busy;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!pd_n)
      cnt <= CNT_W'(PULSE_LEN)); // R12
   AST_PULSE_START: assert property (@(posedge clk) disable iff (!pd_n)
      (pulse_mode && done_evt) |=> (pull_low || !pulse_mode)); // R12
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front #(
   parameter int unsigned ADDR_W    = 23,
   parameter int unsigned LANE_W    = 8,
   parameter int unsigned PULSE_LEN = 4
) (
   input  logic                clk,
   input  logic                pd_n,
   input  logic                ce0_n,
   input  logic                ce1_n,
   input  logic                ce2,
   input  logic                oe_n,
   input  logic                we_n,
   input  logic                wide_mode,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [2*LANE_W-1:0] dq_in,
   output logic [2*LANE_W-1:0] dq_out,
   output logic [2*LANE_W-1:0] dq_oe,
   output logic [ADDR_W-2:0]   word_addr,
   input  logic [2*LANE_W-1:0] array_rdata,
   input  logic [2*LANE_W-1:0] ident_rdata,
   input  logic [2*LANE_W-1:0] query_rdata,
   input  logic [LANE_W-1:0]   status_in,
   input  logic                mode_set_valid,
   input  logic [1:0]          mode_set_val,
   input  logic                wsm_busy,
   input  logic                done_evt,
   input  logic                sts_pulse_mode,
   output logic                sts_pull_low,
   output logic                wr_valid,
   output logic [ADDR_W-2:0]   wr_word_addr,
   output logic                wr_byte_hi,
   output logic                wr_wide,
   output logic [2*LANE_W-1:0] wr_data
);
   localparam int unsigned DATA_W = 2 * LANE_W;

   initial begin
      assert (ADDR_W >= 2)    else $error("ADDR_W must be at least 2");
      assert (LANE_W >= 8)    else $error("LANE_W must hold status bit 7");
      assert (PULSE_LEN >= 1) else $error("PULSE_LEN must be at least 1");
   end

   logic sel;
   logic rd_en;
   logic byte_hi;

   assign word_addr = addr[ADDR_W-1:1];
   assign byte_hi   = ~wide_mode & addr[0];

   fbf_select u_sel (
      .ce0_n (ce0_n), .ce1_n (ce1_n), .ce2 (ce2), .oe_n (oe_n), .pd_n (pd_n),
      .sel (sel), .rd_en (rd_en)
   );

   fbf_read_path #(.LANE_W(LANE_W)) u_rd (
      .clk (clk), .pd_n (pd_n), .rd_en (rd_en), .wide_mode (wide_mode),
      .byte_hi (byte_hi), .busy (wsm_busy),
      .mode_set_valid (mode_set_valid), .mode_set_val (mode_set_val),
      .array_rdata (array_rdata), .ident_rdata (ident_rdata),
      .query_rdata (query_rdata), .status_in (status_in),
      .dq_out (dq_out), .dq_oe (dq_oe)
   );

   fbf_write_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk (clk), .pd_n (pd_n), .sel (sel), .we_n (we_n),
      .wide_mode (wide_mode), .addr (addr), .dq_in (dq_in),
      .wr_valid (wr_valid), .wr_word_addr (wr_word_addr),
      .wr_byte_hi (wr_byte_hi), .wr_wide (wr_wide), .wr_data (wr_data)
   );

   fbf_sts_drive #(.PULSE_LEN(PULSE_LEN)) u_sts (
      .clk (clk), .pd_n (pd_n), .pulse_mode (sts_pulse_mode),
      .busy (wsm_busy), .done_evt (done_evt), .pull_low (sts_pull_low)
   );

   AST_WADDR_MAP: assert property (@(posedge clk) disable iff (!pd_n)
      wr_valid |-> wr_word_addr == $past(word_addr)); // R4
endmodule

// File: tb/tb_flash_bus_front.sv
module tb_flash_bus_front;
   localparam int unsigned AW = 6;
   localparam int unsigned LW = 8;
   localparam int unsigned PL = 4;

   logic          clk = 1'b0;
   logic          pd_n, ce0_n, ce1_n, ce2, oe_n, we_n, wide_mode;
   logic [AW-1:0] addr;
   logic [15:0]   dq_in, dq_out, dq_oe;
   logic [AW-2:0] word_addr, wr_word_addr;
   logic [15:0]   array_rdata, ident_rdata, query_rdata, wr_data;
   logic [7:0]    status_in;
   logic          mode_set_valid;
   logic [1:0]    mode_set_val;
   logic          wsm_busy, done_evt, sts_pulse_mode, sts_pull_low;
   logic          wr_valid, wr_byte_hi, wr_wide;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   assign array_rdata = 16'hA000 | 16'(word_addr);
   assign ident_rdata = 16'h1289;
   assign query_rdata = 16'h5251;

   flash_bus_front #(.ADDR_W(AW), .LANE_W(LW), .PULSE_LEN(PL)) dut (
      .clk (clk), .pd_n (pd_n), .ce0_n (ce0_n), .ce1_n (ce1_n), .ce2 (ce2),
      .oe_n (oe_n), .we_n (we_n), .wide_mode (wide_mode), .addr (addr),
      .dq_in (dq_in), .dq_out (dq_out), .dq_oe (dq_oe), .word_addr (word_addr),
      .array_rdata (array_rdata), .ident_rdata (ident_rdata),
      .query_rdata (query_rdata), .status_in (status_in),
      .mode_set_valid (mode_set_valid), .mode_set_val (mode_set_val),
      .wsm_busy (wsm_busy), .done_evt (done_evt),
      .sts_pulse_mode (sts_pulse_mode), .sts_pull_low (sts_pull_low),
      .wr_valid (wr_valid), .wr_word_addr (wr_word_addr),
      .wr_byte_hi (wr_byte_hi), .wr_wide (wr_wide), .wr_data (wr_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic settle();
      @(negedge clk); #1;
   endtask

   task automatic set_mode(input logic [1:0] m);
      @(negedge clk); mode_set_valid = 1'b1; mode_set_val = m;
      @(negedge clk); mode_set_valid = 1'b0; #1;
   endtask

   task automatic read_on();
      ce0_n = 1'b0; ce1_n = 1'b0; ce2 = 1'b1; oe_n = 1'b0;
   endtask

   task automatic t_reset();
      pd_n = 1'b0; ce0_n = 1'b1; ce1_n = 1'b1; ce2 = 1'b0; oe_n = 1'b1; we_n = 1'b1;
      wide_mode = 1'b1; addr = '0; dq_in = '0; status_in = 8'h80;
      mode_set_valid = 1'b0; mode_set_val = 2'd0; wsm_busy = 1'b0;
      done_evt = 1'b0; sts_pulse_mode = 1'b0;
      repeat (3) @(negedge clk);
      read_on(); #1;
      chk("R1 reset float", 32'(dq_oe), 32'h0);
      chk("R10 no write in reset", 32'(wr_valid), 32'h0);
      @(negedge clk); pd_n = 1'b1; #1;
   endtask

   task automatic t_select();
      addr = 6'b101101; wide_mode = 1'b1;
      read_on(); #1;
      chk("R1 selected drive", 32'(dq_oe), 32'hFFFF);
      ce0_n = 1'b1; #1; chk("R1 ce0_n high", 32'(dq_oe), 32'h0);
      ce0_n = 1'b0; ce1_n = 1'b1; #1; chk("R1 ce1_n high", 32'(dq_oe), 32'h0);
      ce1_n = 1'b0; ce2 = 1'b0; #1; chk("R1 ce2 low", 32'(dq_oe), 32'h0);
      ce2 = 1'b1; oe_n = 1'b1; #1; chk("R1 oe_n high", 32'(dq_oe), 32'h0);
      oe_n = 1'b0; #1;
   endtask

   task automatic t_x16();
      wide_mode = 1'b1; read_on();
      addr = 6'b101101; #1;
      chk("R4 word addr", 32'(word_addr), 32'h16);
      chk("R2 x16 data", 32'(dq_out), 32'hA016);
      addr = 6'b101100; #1;
      chk("R2 addr0 ignored", 32'(dq_out), 32'hA016);
      chk("R2 x16 enables", 32'(dq_oe), 32'hFFFF);
   endtask

   task automatic t_x8();
      wide_mode = 1'b0; read_on();
      addr = 6'b100011; #1;
      chk("R4 word addr x8", 32'(word_addr), 32'h11);
      chk("R3 x8 high byte", 32'(dq_out[7:0]), 32'hA0);
      chk("R3 x8 high lane off", 32'(dq_oe), 32'h00FF);
      addr = 6'b100010; #1;
      chk("R3 x8 low byte", 32'(dq_out[7:0]), 32'h11);
      wide_mode = 1'b1; #1;
   endtask

   task automatic t_modes();
      wide_mode = 1'b1; read_on();
      set_mode(2'd1); chk("R5 identifier", 32'(dq_out), 32'h1289);
      set_mode(2'd2); chk("R5 query", 32'(dq_out), 32'h5251);
      set_mode(2'd0); addr = 6'b000110; #1;
      chk("R5 array", 32'(dq_out), 32'hA003);
   endtask

   task automatic t_status();
      status_in = 8'h98; read_on();
      set_mode(2'd3);
      wide_mode = 1'b1; #1;
      chk("R6 status x16 oe", 32'(dq_oe), 32'h00FF);
      chk("R6 status x16 data", 32'(dq_out[7:0]), 32'h98);
      wide_mode = 1'b0; addr = 6'b000001; #1;
      chk("R6 status x8 odd", 32'(dq_out[7:0]), 32'h98);
      chk("R6 status x8 oe", 32'(dq_oe), 32'h00FF);
      wide_mode = 1'b1;
      set_mode(2'd0);
   endtask

   task automatic t_busy();
      read_on(); wide_mode = 1'b1; wsm_busy = 1'b1; #1;
      chk("R7 busy oe", 32'(dq_oe), 32'h0080);
      chk("R7 busy bit7", 32'(dq_out[7]), 32'h0);
      set_mode(2'd3);
      chk("R7 busy status oe", 32'(dq_oe), 32'h0080);
      set_mode(2'd0);
      wsm_busy = 1'b0; #1;
   endtask

   task automatic do_write(input logic wide, input logic [AW-1:0] a, input logic [15:0] d);
      @(negedge clk); wide_mode = wide; addr = a; dq_in = d; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
      @(posedge clk); #1;
   endtask

   task automatic t_write();
      oe_n = 1'b1; ce0_n = 1'b0; ce1_n = 1'b0; ce2 = 1'b1;
      do_write(1'b1, 6'b110011, 16'hBEEF);
      chk("R8 valid x16", 32'(wr_valid), 32'h1);
      chk("R8 addr x16", 32'(wr_word_addr), 32'h19);
      chk("R8 byte_hi x16", 32'(wr_byte_hi), 32'h0);
      chk("R8 data x16", 32'(wr_data), 32'hBEEF);
      chk("R8 wide x16", 32'(wr_wide), 32'h1);
      @(posedge clk); #1;
      chk("R8 single cycle", 32'(wr_valid), 32'h0);
      do_write(1'b0, 6'b000101, 16'h0042);
      chk("R8 valid x8", 32'(wr_valid), 32'h1);
      chk("R8 byte_hi x8", 32'(wr_byte_hi), 32'h1);
      chk("R8 addr x8", 32'(wr_word_addr), 32'h02);
      chk("R8 wide x8", 32'(wr_wide), 32'h0);
      wide_mode = 1'b1;
   endtask

   task automatic t_write_desel();
      ce2 = 1'b0;
      do_write(1'b1, 6'b010101, 16'h1111);
      chk("R9 no write deselected", 32'(wr_valid), 32'h0);
      @(posedge clk); #1;
      chk("R9 no write later", 32'(wr_valid), 32'h0);
      ce2 = 1'b1;
   endtask

   task automatic t_reset_mode();
      read_on(); wide_mode = 1'b1; addr = 6'b000010;
      set_mode(2'd2);
      chk("R10 pre query", 32'(dq_out), 32'h5251);
      @(negedge clk); pd_n = 1'b0;
      mode_set_valid = 1'b1; mode_set_val = 2'd1;
      @(negedge clk); mode_set_valid = 1'b0;
      @(negedge clk); pd_n = 1'b1; #1;
      chk("R10 array after reset", 32'(dq_out), 32'hA001);
   endtask

   task automatic t_sts();
      sts_pulse_mode = 1'b0;
      @(negedge clk); wsm_busy = 1'b1; #1;
      chk("R11 level busy", 32'(sts_pull_low), 32'h1);
      wsm_busy = 1'b0; #1;
      chk("R11 level ready", 32'(sts_pull_low), 32'h0);
      oe_n = 1'b1;
      sts_pulse_mode = 1'b1;
      @(negedge clk); done_evt = 1'b1; #1;
      chk("R12 before edge", 32'(sts_pull_low), 32'h0);
      @(negedge clk); done_evt = 1'b0; #1;
      for (int i = 1; i < PL; i++) begin
         chk("R12 pulse on", 32'(sts_pull_low), 32'h1);
         settle();
      end
      chk("R12 last pulse cycle", 32'(sts_pull_low), 32'h1);
      settle();
      chk("R12 pulse released", 32'(sts_pull_low), 32'h0);
      @(negedge clk); done_evt = 1'b1;
      @(negedge clk); done_evt = 1'b0;
      settle(); settle();
      done_evt = 1'b1;
      @(negedge clk); done_evt = 1'b0; #1;
      for (int i = 0; i < PL; i++) begin
         chk("R12 retrigger", 32'(sts_pull_low), 32'h1);
         settle();
      end
      chk("R12 retrigger released", 32'(sts_pull_low), 32'h0);
      sts_pulse_mode = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_select();
      t_x16();
      t_x8();
      t_modes();
      t_status();
      t_busy();
      t_write();
      t_write_desel();
      t_reset_mode();
      t_sts();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule